// File: doc/BRIEF.md
# Half-Bridge Shoot-Through Interlock with Latched Fault

The block sits between the PWM command pins of a three-phase inverter and the internal gate enables. Each phase has an upper and a lower command input, both active low (0 requests the switch ON, 1 requests it OFF). All commands are brought into the clock domain through a two-stage synchronizer. While a phase is healthy its two gate enables follow their commands. A separate brake command passes straight through to its gate enable and is never checked against anything.

If both commands of one phase ask for ON, and that overlap lasts for a programmable number of consecutive sampled cycles, the phase trips. Its latch sets, both of its gate enables are forced low, and the shared active-low fault output goes low. Each phase keeps its own latch, and the fault output is low while any latch is set. A latch clears only after each of the two commands of that phase has made an OFF-to-ON (1-to-0) transition since the trip. It clears on the later of those two transitions. Only then does the phase return to following its commands.

Top module: `shoot_guard`

## Requirements
- R1: During and after reset, with all commands at 1, every gate enable (gate_hi, gate_lo, gate_brk) is 0 and fault_n is 1.
- R2: With no fault latched in a phase, gate_hi[i] is 1 exactly when cmd_hi_n[i] is 0, and gate_lo[i] is 1 exactly when cmd_lo_n[i] is 0. Bit i of each vector belongs to phase i. The outputs reflect a command change within three clock cycles.
- R3: When cmd_hi_n[i] and cmd_lo_n[i] are both 0 for QUAL_CYC consecutive sampled cycles, phase i latches a fault. While the latch is set, gate_hi[i] and gate_lo[i] are both 0, whatever the commands.
- R4: An overlap of both commands of a phase that lasts fewer than QUAL_CYC sampled cycles latches nothing. While such an overlap lasts, the gates keep following the commands.
- R5: A trip in one phase leaves the gate enables of the other phases following their own commands.
- R6: fault_n is 0 while at least one phase latch is set, and 1 once every latch has cleared.
- R7: gate_brk is 1 exactly when cmd_brk_n is 0. This holds even while a phase fault is latched.
- R8: A latched phase stays latched through any command activity, up to the point where both of its commands have made a 1-to-0 transition since the trip. This includes both commands returning to 1 and a single command making one or more 1-to-0 transitions.
- R9: A latched phase clears on the 1-to-0 transition that completes the pair, the later of the two. From then on its gates follow the commands again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_hi_n | input | NPH | Upper-arm commands, active low, bit i = phase i |
| cmd_lo_n | input | NPH | Lower-arm commands, active low, bit i = phase i |
| cmd_brk_n | input | 1 | Brake command, active low |
| gate_hi | output | NPH | Upper-arm gate enables, active high |
| gate_lo | output | NPH | Lower-arm gate enables, active high |
| gate_brk | output | 1 | Brake gate enable, active high |
| fault_n | output | 1 | Shared interlock fault flag, active low |

## Verification
The assertions assume that the commands are quasi-static compared with the clock. Every change is meant to pass the synchronizer as one clean step, so that a 1-to-0 transition of a command shows up as exactly one sampled edge. The stimulus meets this by changing commands only on the falling clock edge and holding each pattern for several cycles. It also never lets both commands of a phase fall in the same cycle while that phase is latched. Overlaps are kept either well short of, or well beyond, QUAL_CYC, so that no check depends on the exact cycle of qualification.

// File: rtl/shoot_guard_pkg.sv
package shoot_guard_pkg;

  // Both commands of a pair request ON (active low).
  function automatic logic pair_overlap(input logic hi_n, input logic lo_n);
    return !hi_n && !lo_n;
  endfunction

  // Next value of the overlap qualification counter, saturating at limit-1.
  function automatic int unsigned qual_next(input int unsigned cnt,
                                            input logic overlap,
                                            input int unsigned limit);
    if (!overlap) return 0;
    if (cnt + 1 >= limit) return limit - 1;
    return cnt + 1;
  endfunction

  // Sampled 1-to-0 transition of an active-low command.
  function automatic logic on_edge(input logic prev_n, input logic cur_n);
    return prev_n && !cur_n;
  endfunction

endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '1;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sg_phase.sv
module sg_phase
  import shoot_guard_pkg::*;
#(
  parameter int QUAL_CYC = 16,
  localparam int CW = $clog2(QUAL_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_s,
  input  logic lo_s,
  output logic gate_hi,
  output logic gate_lo,
  output logic latched,
  output logic trip,
  output logic clr
);
  logic [CW-1:0] cnt;
  logic          hi_q, lo_q;
  logic          seen_hi, seen_lo;
  logic          latch_q;
  logic          both, hi_fall, lo_fall;

  assign both    = pair_overlap(hi_s, lo_s);
  assign hi_fall = on_edge(hi_q, hi_s);
  assign lo_fall = on_edge(lo_q, lo_s);

  assign trip = !latch_q && both && (cnt == CW'(QUAL_CYC - 1));
  assign clr  = latch_q && (seen_hi || hi_fall) && (seen_lo || lo_fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= 1'b1;
      lo_q    <= 1'b1;
      cnt     <= '0;
      latch_q <= 1'b0;
      seen_hi <= 1'b0;
      seen_lo <= 1'b0;
    end else begin
      hi_q <= hi_s;
      lo_q <= lo_s;
      if (latch_q) cnt <= '0;
      else         cnt <= CW'(qual_next(32'(cnt), both, QUAL_CYC));
      if (trip)     latch_q <= 1'b1;
      else if (clr) latch_q <= 1'b0;
      if (latch_q && !clr) begin
        seen_hi <= seen_hi || hi_fall;
        seen_lo <= seen_lo || lo_fall;
      end else begin
        seen_hi <= 1'b0;
        seen_lo <= 1'b0;
      end
    end
  end

  assign latched = latch_q;
  assign gate_hi = !hi_s && !latch_q;
  assign gate_lo = !lo_s && !latch_q;
endmodule

// File: rtl/shoot_guard.sv
module shoot_guard #(
  parameter int NPH      = 3,
  parameter int SYNC_STG = 2,
  parameter int QUAL_CYC = 16,
  localparam int SW = 2 * NPH + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] cmd_hi_n,
  input  logic [NPH-1:0] cmd_lo_n,
  input  logic           cmd_brk_n,
  output logic [NPH-1:0] gate_hi,
  output logic [NPH-1:0] gate_lo,
  output logic           gate_brk,
  output logic           fault_n
);
  logic [SW-1:0]  sync_q;
  logic [NPH-1:0] hi_s, lo_s;
  logic           brk_s;
  logic [NPH-1:0] ph_latch, ph_trip, ph_clr;

  sg_sync #(.W(SW), .STAGES(SYNC_STG)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cmd_brk_n, cmd_lo_n, cmd_hi_n}),
    .q     (sync_q)
  );

  assign hi_s  = sync_q[NPH-1:0];
  assign lo_s  = sync_q[2*NPH-1:NPH];
  assign brk_s = sync_q[SW-1];

  for (genvar i = 0; i < NPH; i++) begin : g_ph
    sg_phase #(.QUAL_CYC(QUAL_CYC)) u_ph (
      .clk     (clk),
      .rst_n   (rst_n),
      .hi_s    (hi_s[i]),
      .lo_s    (lo_s[i]),
      .gate_hi (gate_hi[i]),
      .gate_lo (gate_lo[i]),
      .latched (ph_latch[i]),
      .trip    (ph_trip[i]),
      .clr     (ph_clr[i])
    );
  end

  assign gate_brk = !brk_s;
  assign fault_n  = !(|ph_latch);
endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
  parameter int NPH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NPH-1:0] gate_hi,
  input logic [NPH-1:0] gate_lo,
  input logic           fault_n,
  input logic [NPH-1:0] hi_s,
  input logic [NPH-1:0] lo_s,
  input logic [NPH-1:0] ph_latch,
  input logic [NPH-1:0] ph_trip,
  input logic [NPH-1:0] ph_clr
);
  for (genvar i = 0; i < NPH; i++) begin : g_chk
    assert_latched_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ph_latch[i] |-> (!gate_hi[i] && !gate_lo[i]));

    assert_set_needs_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ph_latch[i]) |-> $past(!hi_s[i] && !lo_s[i]));

    assert_trip_raises_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ph_trip[i] |=> !fault_n);

    assert_clear_on_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ph_latch[i]) |->
        (($past(hi_s[i], 2) && !$past(hi_s[i])) ||
         ($past(lo_s[i], 2) && !$past(lo_s[i]))));

    assert_clear_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ph_clr[i] |=> !ph_latch[i]);
  end
endmodule

bind shoot_guard sg_checker #(.NPH(NPH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .gate_hi  (gate_hi),
  .gate_lo  (gate_lo),
  .fault_n  (fault_n),
  .hi_s     (hi_s),
  .lo_s     (lo_s),
  .ph_latch (ph_latch),
  .ph_trip  (ph_trip),
  .ph_clr   (ph_clr)
);

// File: tb/tb_shoot_guard.sv
`timescale 1ns/1ps
module tb_shoot_guard;
  localparam int Q = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hi_n = 3'b111, lo_n = 3'b111;
  logic       brk_n = 1'b1;
  logic [2:0] g_hi, g_lo;
  logic       g_brk, f_n;

  typedef struct {
    logic [2:0] ehi;
    logic [2:0] elo;
    logic       ebrk;
    logic       efn;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  always #2.5 clk = ~clk;

  shoot_guard #(.NPH(3), .SYNC_STG(2), .QUAL_CYC(Q)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_hi_n(hi_n), .cmd_lo_n(lo_n),
    .cmd_brk_n(brk_n), .gate_hi(g_hi), .gate_lo(g_lo),
    .gate_brk(g_brk), .fault_n(f_n)
  );

  task automatic step(input logic [2:0] h, input logic [2:0] l, input logic b,
                      input int n, input logic [2:0] ehi, input logic [2:0] elo,
                      input logic eb, input logic ef, input string tag);
    exp_t e;
    hi_n = h; lo_n = l; brk_n = b;
    repeat (n) @(negedge clk);
    e.ehi = ehi; e.elo = elo; e.ebrk = eb; e.efn = ef; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      wait (q.size() != 0);
      #1;
      e = q.pop_front();
      checks++;
      if (g_hi !== e.ehi || g_lo !== e.elo || g_brk !== e.ebrk || f_n !== e.efn) begin
        fails++;
        $display("FAIL %s: actual hi=%b lo=%b brk=%b fault_n=%b expected hi=%b lo=%b brk=%b fault_n=%b",
                 e.tag, g_hi, g_lo, g_brk, f_n, e.ehi, e.elo, e.ebrk, e.efn);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (4) @(negedge clk);
    step(3'b111, 3'b111, 1'b1, 1, 3'b000, 3'b000, 1'b0, 1'b1, "R1 in reset");
    rst_n = 1'b1;
    step(3'b111, 3'b111, 1'b1, 4, 3'b000, 3'b000, 1'b0, 1'b1, "R1 after reset");
    // R2: follow commands
    step(3'b110, 3'b111, 1'b1, 4, 3'b001, 3'b000, 1'b0, 1'b1, "R2 upper ph0");
    step(3'b111, 3'b101, 1'b1, 4, 3'b000, 3'b010, 1'b0, 1'b1, "R2 lower ph1");
    // R7: brake passes through
    step(3'b011, 3'b101, 1'b0, 4, 3'b100, 3'b010, 1'b1, 1'b1, "R7 brake on");
    // R4: short overlap on ph2
    step(3'b011, 3'b001, 1'b1, Q-4, 3'b100, 3'b110, 1'b0, 1'b1, "R4 overlap in progress");
    step(3'b011, 3'b101, 1'b1, 4, 3'b100, 3'b010, 1'b0, 1'b1, "R4 short overlap no trip");
    // R3/R5: long overlap on ph0, ph1 lower and ph2 upper keep following
    step(3'b010, 3'b100, 1'b0, Q+4, 3'b100, 3'b010, 1'b1, 1'b0, "R3 R5 R7 ph0 tripped");
    // R8: release both, then one fall, then its rise
    step(3'b011, 3'b101, 1'b1, 4, 3'b100, 3'b010, 1'b0, 1'b0, "R8 both released");
    step(3'b011, 3'b100, 1'b1, 4, 3'b100, 3'b010, 1'b0, 1'b0, "R8 lower fall only");
    step(3'b011, 3'b101, 1'b1, 4, 3'b100, 3'b010, 1'b0, 1'b0, "R8 lower risen again");
    step(3'b011, 3'b100, 1'b1, 4, 3'b100, 3'b010, 1'b0, 1'b0, "R8 second lower fall");
    step(3'b011, 3'b101, 1'b1, 4, 3'b100, 3'b010, 1'b0, 1'b0, "R8 lower risen twice");
    // R9: later fall (upper) clears
    step(3'b010, 3'b101, 1'b1, 4, 3'b101, 3'b010, 1'b0, 1'b1, "R9 clear on later fall");
    step(3'b111, 3'b111, 1'b1, 4, 3'b000, 3'b000, 1'b0, 1'b1, "R2 idle");
    // R6: two phases trip
    step(3'b001, 3'b001, 1'b1, Q+4, 3'b000, 3'b000, 1'b0, 1'b0, "R3 R6 ph1 ph2 tripped");
    step(3'b111, 3'b111, 1'b1, 4, 3'b000, 3'b000, 1'b0, 1'b0, "R6 released");
    step(3'b111, 3'b101, 1'b1, 4, 3'b000, 3'b000, 1'b0, 1'b0, "R8 ph1 lower fall");
    step(3'b111, 3'b111, 1'b1, 4, 3'b000, 3'b000, 1'b0, 1'b0, "R8 ph1 lower risen");
    step(3'b101, 3'b111, 1'b1, 4, 3'b010, 3'b000, 1'b0, 1'b0, "R6 ph1 cleared ph2 held");
    step(3'b111, 3'b011, 1'b1, 4, 3'b000, 3'b000, 1'b0, 1'b0, "R8 ph2 lower fall");
    step(3'b111, 3'b111, 1'b1, 4, 3'b000, 3'b000, 1'b0, 1'b0, "R8 ph2 lower risen");
    step(3'b011, 3'b111, 1'b1, 4, 3'b100, 3'b000, 1'b0, 1'b1, "R6 R9 all cleared");
    step(3'b110, 3'b011, 1'b0, 4, 3'b001, 3'b100, 1'b1, 1'b1, "R2 R7 normal after clear");
    wait (q.size() == 0);
    #2;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule